// File: doc/BRIEF.md
# Status Transition Capture Registers

This block watches a 16-bit live status word from the rest of an instrument controller. It keeps two sticky change registers. One gathers bits whose status went from 1 to 0; the other gathers bits whose status went from 0 to 1. A status bit that rises and then falls again leaves a mark in both registers, and that mark stays until software clears it.

Each change register is paired with an enable mask of the same width. A single summary output is high whenever any change bit is set and its enable bit is 1. Host software reaches the registers through a plain address/strobe port. Reading a change register returns its contents and empties it. A separate clear-status strobe empties both change registers at once. Command decoding, the bus transport and service-request logic live elsewhere.

Top module: `stx_status_regs`

## Requirements
- R1: A status bit that goes from 1 to 0 sets the same bit of the falling-change register, address 1.
- R2: A status bit that goes from 0 to 1 sets the same bit of the rising-change register, address 2.
- R3: Change bits are sticky. A set bit stays 1 when the status bit later returns to its earlier level, until a clear.
- R4: A read of a change register returns its current contents in the strobe cycle and leaves the register at zero afterwards. A second read returns zero.
- R5: A one-cycle pulse on clr_i zeroes both change registers and leaves both enable masks unchanged.
- R6: A transition captured in the same cycle as a clearing read or a clr_i pulse wins: its bit is 1 after that cycle.
- R7: The falling enable mask (address 3) and the rising enable mask (address 4) can be written and read back.
- R8: summary_o is the OR over both registers of (change bit AND enable bit). It rises in the cycle after the change bit is captured and falls once the enabled bits are cleared.
- R9: While both enable masks are all zero, summary_o stays 0 whatever transitions occur.
- R10: A read of address 0 returns the sampled status word and does not alter either change register.
- R11: Writes to addresses 0, 1 and 2 have no effect on any register.
- R12: After reset, both change registers and both enable masks read 0. A status word that is already nonzero during reset causes no captured transition.
- R13: A change on status_i ahead of clock edge k is visible in a change register after edge k+1. Register stages: one input sample, then the capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| status_i | input | 16 | Live instrument status word |
| addr_i | input | 3 | Register address (0 live, 1 fall change, 2 rise change, 3 fall enable, 4 rise enable) |
| rd_i | input | 1 | Read strobe; rdata_o is valid while high |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| clr_i | input | 1 | Clear-status strobe |
| rdata_o | output | 16 | Read data, zero when rd_i is low |
| summary_o | output | 1 | Masked OR of both change registers |

## Verification
A table of status words is applied in sequence. Its steps include pure rises, pure falls, mixed rise and fall in one step, all-ones to all-zeros, an unchanged word, and a word that shares one held bit with its predecessor. Together these tell the two edge directions apart and show that held bits raise no change. Directed cases place a transition in exactly the cycle of a clearing read or a clr_i pulse, which tells a design where the new event wins from one where it is lost. Other directed cases toggle a bit up and back down to separate sticky capture from level following. They also set the enable masks one direction at a time, to show that a change in the opposite direction leaves summary_o low.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam int STX_ADDR_W = 3;

  typedef enum logic [STX_ADDR_W-1:0] {
    ADDR_LIVE     = 3'd0,
    ADDR_FALL_CHG = 3'd1,
    ADDR_RISE_CHG = 3'd2,
    ADDR_FALL_EN  = 3'd3,
    ADDR_RISE_EN  = 3'd4
  } stx_addr_e;

  localparam int DIR_FALL = 0;
  localparam int DIR_RISE = 1;
  localparam int NUM_DIR  = 2;
endpackage

// File: rtl/stx_edge_det.sv
module stx_edge_det #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  output logic [W-1:0] live_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] samp_q, prev_q;
  logic         init_q;

  // first sample after reset seeds both stages, so no edge is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      prev_q <= '0;
      init_q <= 1'b1;
    end else begin
      samp_q <= status_i;
      prev_q <= init_q ? status_i : samp_q;
      init_q <= 1'b0;
    end
  end

  assign live_o = samp_q;
  assign rise_o = samp_q & ~prev_q;
  assign fall_o = prev_q & ~samp_q;

  assert_first_sample_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_q |=> (rise_o == '0 && fall_o == '0));

  assert_edge_follows_input_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_q && status_i != samp_q) |=> ((rise_o | fall_o) == ($past(status_i) ^ $past(samp_q))));
endmodule

// File: rtl/stx_capture.sv
module stx_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  // a fresh event outranks a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= (clr_i ? '0 : q_q) | set_i;
  end

  assign q_o = q_q;

  assert_set_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

  assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

  assert_clear_empties_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && set_i == '0) |=> (q_o == '0));
endmodule

// File: rtl/stx_host_if.sv
module stx_host_if
  import stx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [STX_ADDR_W-1:0]         addr_i,
  input  logic                          rd_i,
  input  logic                          wr_i,
  input  logic [W-1:0]                  wdata_i,
  input  logic [W-1:0]                  live_i,
  input  logic [NUM_DIR-1:0][W-1:0]     chg_i,
  output logic [NUM_DIR-1:0][W-1:0]     en_o,
  output logic [NUM_DIR-1:0]            rd_clr_o,
  output logic [W-1:0]                  rdata_o
);
  localparam logic [STX_ADDR_W-1:0] CHG_ADDR [NUM_DIR] = '{ADDR_FALL_CHG, ADDR_RISE_CHG};
  localparam logic [STX_ADDR_W-1:0] EN_ADDR  [NUM_DIR] = '{ADDR_FALL_EN,  ADDR_RISE_EN};

  logic [NUM_DIR-1:0][W-1:0] en_q;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          en_q[g] <= '0;
      else if (wr_i && addr_i == EN_ADDR[g]) en_q[g] <= wdata_i;
    end
    assign rd_clr_o[g] = rd_i && (addr_i == CHG_ADDR[g]);

    assert_en_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == EN_ADDR[g]) |=> (en_o[g] == $past(wdata_i)));
  end

  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_LIVE:     rdata_o = live_i;
        ADDR_FALL_CHG: rdata_o = chg_i[DIR_FALL];
        ADDR_RISE_CHG: rdata_o = chg_i[DIR_RISE];
        ADDR_FALL_EN:  rdata_o = en_q[DIR_FALL];
        ADDR_RISE_EN:  rdata_o = en_q[DIR_RISE];
        default:       rdata_o = '0;
      endcase
    end
  end

  assert_ro_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != ADDR_FALL_EN && addr_i != ADDR_RISE_EN) |=> $stable(en_o));
endmodule

// File: rtl/stx_status_regs.sv
module stx_status_regs
  import stx_pkg::*;
#(
  parameter int STAT_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [STAT_W-1:0]     status_i,
  input  logic [STX_ADDR_W-1:0] addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [STAT_W-1:0]     wdata_i,
  input  logic                  clr_i,
  output logic [STAT_W-1:0]     rdata_o,
  output logic                  summary_o
);
  logic [STAT_W-1:0]              live;
  logic [NUM_DIR-1:0][STAT_W-1:0] edge_v;
  logic [NUM_DIR-1:0][STAT_W-1:0] chg_q;
  logic [NUM_DIR-1:0][STAT_W-1:0] en_q;
  logic [NUM_DIR-1:0]             rd_clr;
  logic [NUM_DIR-1:0]             hit;

  stx_edge_det #(.W(STAT_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_i),
    .live_o   (live),
    .rise_o   (edge_v[DIR_RISE]),
    .fall_o   (edge_v[DIR_FALL])
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_cap
    stx_capture #(.W(STAT_W)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (edge_v[g]),
      .clr_i  (clr_i | rd_clr[g]),
      .q_o    (chg_q[g])
    );
    assign hit[g] = |(chg_q[g] & en_q[g]);
  end

  stx_host_if #(.W(STAT_W)) u_host (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .live_i   (live),
    .chg_i    (chg_q),
    .en_o     (en_q),
    .rd_clr_o (rd_clr),
    .rdata_o  (rdata_o)
  );

  assign summary_o = |hit;

  always_comb begin
    if (rst_ni && en_q == '0)
      assert_summary_masked_R9: assert (!summary_o);
  end

  assert_summary_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && ((|(edge_v[DIR_FALL] & en_q[DIR_FALL])) || (|(edge_v[DIR_RISE] & en_q[DIR_RISE]))))
      |=> summary_o);
endmodule

// File: tb/stx_status_regs_bench.sv
module stx_status_regs_bench;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  status_i = '0;
  logic [2:0]    addr_i = '0;
  logic          rd_i = 1'b0;
  logic          wr_i = 1'b0;
  logic [W-1:0]  wdata_i = '0;
  logic          clr_i = 1'b0;
  logic [W-1:0]  rdata_o;
  logic          summary_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  stx_status_regs #(.STAT_W(W)) u_stx_status_regs (
    .clk_i (clk), .rst_ni (rst_ni), .status_i (status_i), .addr_i (addr_i),
    .rd_i (rd_i), .wr_i (wr_i), .wdata_i (wdata_i), .clr_i (clr_i),
    .rdata_o (rdata_o), .summary_o (summary_o)
  );

  // {status word, expected fall change, expected rise change}
  localparam logic [47:0] VEC_TAB [0:7] = '{
    {16'h00FF, 16'h0000, 16'h00FF},
    {16'h0F0F, 16'h00F0, 16'h0F00},
    {16'hFFFF, 16'h0000, 16'hF0F0},
    {16'h0000, 16'hFFFF, 16'h0000},
    {16'h8001, 16'h0000, 16'h8001},
    {16'h8001, 16'h0000, 16'h0000},
    {16'h0001, 16'h8000, 16'h0000},
    {16'hA5A5, 16'h0000, 16'hA5A4}
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    addr_i = a;
    rd_i = 1'b1;
    #1 d = rdata_o;
    tick();
    rd_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    addr_i = a;
    wdata_i = d;
    wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
  endtask

  initial begin
    logic [W-1:0] d;
    status_i = 16'h1234;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) tick();

    // reset state, nonzero status at reset
    rd(3'd1, d); check("R12", d, 16'h0000);
    rd(3'd2, d); check("R12", d, 16'h0000);
    rd(3'd3, d); check("R12", d, 16'h0000);
    rd(3'd4, d); check("R12", d, 16'h0000);
    check("R12", {15'd0, summary_o}, 16'd0);
    rd(3'd0, d); check("R10", d, 16'h1234);

    // falling capture and clear-on-read
    status_i = 16'h0000;
    tick(); tick();
    rd(3'd1, d); check("R1", d, 16'h1234);
    rd(3'd1, d); check("R4", d, 16'h0000);
    rd(3'd2, d); check("R2", d, 16'h0000);

    // table walk with masks at zero
    for (int i = 0; i < 8; i++) begin
      status_i = VEC_TAB[i][47:32];
      tick(); tick();
      check("R9", {15'd0, summary_o}, 16'd0);
      rd(3'd1, d); check("R1", d, VEC_TAB[i][31:16]);
      rd(3'd2, d); check("R2", d, VEC_TAB[i][15:0]);
    end

    // sticky: pulse a bit up and down
    status_i = 16'h0000; tick(); tick();
    rd(3'd1, d); rd(3'd2, d);
    status_i = 16'h0001; tick();
    status_i = 16'h0000; tick(); tick();
    rd(3'd2, d); check("R3", d, 16'h0001);
    rd(3'd1, d); check("R3", d, 16'h0001);

    // live read has no side effect
    status_i = 16'h0040; tick(); tick();
    rd(3'd0, d); check("R10", d, 16'h0040);
    rd(3'd2, d); check("R10", d, 16'h0040);

    // enables and summary timing
    wr(3'd4, 16'h0010);
    rd(3'd4, d); check("R7", d, 16'h0010);
    wr(3'd3, 16'h0020);
    rd(3'd3, d); check("R7", d, 16'h0020);
    status_i = 16'h0050; tick();
    check("R13", {15'd0, summary_o}, 16'd0);
    tick();
    check("R8", {15'd0, summary_o}, 16'd1);
    rd(3'd2, d); check("R13", d, 16'h0010);
    check("R8", {15'd0, summary_o}, 16'd0);
    // unmasked direction change leaves summary low
    status_i = 16'h0040; tick(); tick();
    check("R8", {15'd0, summary_o}, 16'd0);
    rd(3'd1, d); check("R1", d, 16'h0010);

    // clear-status keeps enables
    status_i = 16'h0060; tick(); tick();
    check("R8", {15'd0, summary_o}, 16'd0);
    status_i = 16'h0040; tick(); tick();
    check("R8", {15'd0, summary_o}, 16'd1);
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    check("R5", {15'd0, summary_o}, 16'd0);
    rd(3'd1, d); check("R5", d, 16'h0000);
    rd(3'd2, d); check("R5", d, 16'h0000);
    rd(3'd3, d); check("R5", d, 16'h0020);
    rd(3'd4, d); check("R5", d, 16'h0010);

    // event coincident with clr_i
    status_i = 16'h0140; tick();
    clr_i = 1'b1; tick(); clr_i = 1'b0;
    rd(3'd2, d); check("R6", d, 16'h0100);
    // event coincident with clearing read
    status_i = 16'h0340; tick();
    rd(3'd2, d); check("R6", d, 16'h0000);
    rd(3'd2, d); check("R6", d, 16'h0200);

    // writes to read-only addresses
    wr(3'd0, 16'hFFFF);
    wr(3'd1, 16'hFFFF);
    wr(3'd2, 16'hFFFF);
    rd(3'd0, d); check("R11", d, 16'h0340);
    rd(3'd1, d); check("R11", d, 16'h0000);
    rd(3'd2, d); check("R11", d, 16'h0000);
    rd(3'd3, d); check("R11", d, 16'h0020);
    rd(3'd4, d); check("R11", d, 16'h0010);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule